// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is an I2C target that gives an external bus controller read and write access to a bank of 8-bit configuration registers. The registers themselves sit outside the block, behind a plain register-bus port. That port offers an address, write data and a one-cycle write strobe. For reads it has a one-cycle read strobe, with read data returned combinationally in the same cycle. The block samples SCL and SDA through two-flop synchronizers on the system clock. It detects start, stop and repeated-start conditions, and it pulls SDA low through an open-drain enable. It never stretches the clock.

The 7-bit target address is fixed by two four-level strap inputs, each already resolved to one of four levels. The upper strap picks the top five address bits from a small table. The lower strap's level number becomes the bottom two bits. A write transaction carries one sub-address byte and then any number of data bytes, which land at consecutive offsets. A read transaction has no sub-address of its own. It starts at offset 00h after reset, or at the last sub-address a write supplied, or otherwise one past the last byte read. A bench or system tie-off can hold the enable low, and the block then stays deaf to the bus.

Top module: `strap_i2c_target`

## Requirements
- R1: While `en` is low, the block never pulls SDA and issues no register strobe, whatever SCL and SDA do.
- R2: Strap levels are coded 0 = low, 1 = resistor to ground, 2 = floating, 3 = high. The upper strap sets address bits [6:2] as follows: 0 gives 10001, 1 gives 01000, 2 gives 00100 and 3 gives 00011. The lower strap's level number is address bits [1:0]. An address byte whose upper seven bits match is acknowledged.
- R3: An address byte that does not match gets no acknowledge. Every later byte up to the next start is also left unacknowledged, and none of them causes a strobe.
- R4: In a write, the byte after the address is the sub-address. Each following data byte is acknowledged and produces one `reg_we` pulse. The first pulse goes to the sub-address, and each later pulse goes one offset higher.
- R5: A write that holds only a sub-address and then a stop produces no `reg_we` pulse.
- R6: A read sends each register byte MSB first, and the next byte follows only after the controller acknowledges. If a write supplied a sub-address since the previous read, the read starts at that sub-address.
- R7: After reset, a read starts at offset 00h. A read that follows another read with no sub-address written in between continues one past the last byte sent.
- R8: After a read byte that the controller does not acknowledge, SDA stays released and no further `reg_re` pulse occurs until the next start.
- R9: A repeated start ends the current transaction and begins a new address phase, exactly as a start after a stop does.
- R10: The block changes its SDA drive only in response to a low level of the synchronized SCL, never while SCL is high.
- R11: Right after reset, SDA is released and neither register strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bus enable; low makes the target ignore the bus |
| strap_hi | input | 2 | Level of the strap choosing address bits [6:2] |
| strap_lo | input | 2 | Level of the strap choosing address bits [1:0] |
| scl_in | input | 1 | Bus clock as seen on the wire |
| sda_in | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_addr | output | 8 | Register offset for the current access |
| reg_wdata | output | 8 | Data for a register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr`, combinational |
| reg_re | output | 1 | One-cycle strobe marking a register read |

## Verification
On every cycle, the assertions check four things. A disabled target is silent. SDA drive only moves while synchronized SCL is low. The write and read strobes never coincide. After each strobe, the SDA level matches what should follow it: an acknowledge after a write, and the inverted MSB after a read. The rest needs complete bus transactions from the bench scenarios to show. That covers the address table for all sixteen strap settings, the rejection of a wrong address, burst writes to rising offsets, and the three ways the read pointer is chosen. It also covers the silence after a NACK and the effect of a repeated start.

// File: rtl/strap_i2c_target.sv
module strap_i2c_target (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] strap_hi,
  input  logic [1:0] strap_lo,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata,
  output logic       reg_re
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_SUB, S_SACK, S_WR, S_WACK, S_RD, S_RACK
  } st_t;

  st_t        st;
  logic [2:0] scl_p, sda_p;
  logic [7:0] sh, wptr, rptr;
  logic [6:0] tx;
  logic [3:0] cnt;
  logic       rw, mack;
  logic [4:0] hi_bits;
  logic [6:0] dev_addr;

  always_comb begin
    case (strap_hi)
      2'd0:    hi_bits = 5'b10001;
      2'd1:    hi_bits = 5'b01000;
      2'd2:    hi_bits = 5'b00100;
      default: hi_bits = 5'b00011;
    endcase
  end
  assign dev_addr = {hi_bits, strap_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  wire scl_cur  = scl_p[1];
  wire scl_old  = scl_p[2];
  wire sda_cur  = sda_p[1];
  wire sda_old  = sda_p[2];
  wire scl_rise = scl_cur & ~scl_old;
  wire scl_fall = ~scl_cur & scl_old;
  wire start_c  = scl_cur & scl_old & sda_old & ~sda_cur;
  wire stop_c   = scl_cur & scl_old & ~sda_old & sda_cur;
  wire quiet    = ~en | start_c | stop_c;
  wire load_now = scl_fall & ((st == S_AACK & rw) | (st == S_RACK & mack));

  assign reg_addr  = rw ? rptr : wptr;
  assign reg_wdata = sh;
  assign reg_we    = ~quiet & scl_fall & (st == S_WR) & (cnt == 4'd8);
  assign reg_re    = ~quiet & load_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sh     <= '0;
      tx     <= '0;
      cnt    <= '0;
      wptr   <= '0;
      rptr   <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (!en || stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (scl_rise) begin
        case (st)
          S_ADDR, S_SUB, S_WR: begin
            sh  <= {sh[6:0], sda_cur};
            cnt <= cnt + 4'd1;
          end
          S_RD:    cnt  <= cnt + 4'd1;
          S_RACK:  mack <= ~sda_cur;
          default: ;
        endcase
      end
      if (load_now) begin
        tx     <= reg_rdata[6:0];
        sda_oe <= ~reg_rdata[7];
        rptr   <= rptr + 8'd1;
        cnt    <= '0;
        st     <= S_RD;
      end else if (scl_fall) begin
        case (st)
          S_ADDR: if (cnt == 4'd8) begin
            if (sh[7:1] == dev_addr) begin
              sda_oe <= 1'b1;
              rw     <= sh[0];
              st     <= S_AACK;
            end else begin
              st <= S_IDLE;
            end
          end
          S_AACK: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_SUB;
          end
          S_SUB: if (cnt == 4'd8) begin
            wptr   <= sh;
            rptr   <= sh;
            sda_oe <= 1'b1;
            st     <= S_SACK;
          end
          S_SACK, S_WACK: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_WR;
          end
          S_WR: if (cnt == 4'd8) begin
            wptr   <= wptr + 8'd1;
            sda_oe <= 1'b1;
            st     <= S_WACK;
          end
          S_RD: begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= S_RACK;
            end else begin
              sda_oe <= ~tx[6];
              tx     <= {tx[5:0], 1'b0};
            end
          end
          S_RACK: begin
            sda_oe <= 1'b0;
            st     <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module strap_i2c_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       scl_sync,
  input logic       sda_oe,
  input logic       reg_we,
  input logic       reg_re,
  input logic [7:0] reg_rdata
);

  assert_silent_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_oe && !reg_we && !reg_re));

  assert_ack_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> sda_oe);

  assert_no_dual_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  assert_msb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> (sda_oe == !$past(reg_rdata[7])));

  assert_drive_on_low_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && $past(en)) |-> !$past(scl_sync));

endmodule

bind strap_i2c_target strap_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_sync(scl_cur), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
);

// File: tb/tb_strap_i2c_target.sv
module tb_strap_i2c_target;

  localparam int Q = 10;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [1:0] strap_hi = 2'd1;
  logic [1:0] strap_lo = 2'd2;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, reg_re;
  logic       sda_bus;

  logic [7:0] mem [256];
  int checks = 0, fails = 0;
  int we_cnt = 0, re_cnt = 0, oe_cnt = 0, bad_drive = 0, cyc = 0;
  bit done = 0;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus   = m_sda & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  strap_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .en(en), .strap_hi(strap_hi), .strap_lo(strap_lo),
    .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .reg_re(reg_re)
  );

  always @(negedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt++;
    end
    if (reg_re) re_cnt++;
    if (sda_oe) oe_cnt++;
    if (sda_oe != prev_oe && m_scl) bad_drive++;
    prev_oe = sda_oe;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_addr(input logic [1:0] a1, input logic [1:0] a0);
    logic [4:0] hi;
    case (a1)
      2'd0: hi = 5'b10001;
      2'd1: hi = 5'b01000;
      2'd2: hi = 5'b00100;
      default: hi = 5'b00011;
    endcase
    return {hi, a0};
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wclk(Q);
    m_scl = 1'b1; wclk(H);
    m_sda = 1'b0; wclk(H);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic i2c_stop();
    wclk(Q); m_sda = 1'b0; wclk(Q);
    m_scl = 1'b1; wclk(H);
    m_sda = 1'b1; wclk(H);
  endtask

  task automatic put_bit(input logic b);
    wclk(Q); m_sda = b; wclk(Q);
    m_scl = 1'b1; wclk(H);
    m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic v);
    m_sda = 1'b1; wclk(2 * Q);
    m_scl = 1'b1; wclk(Q);
    v = sda_bus; wclk(Q);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(v);
    acked = ~v;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(v);
      d[i] = v;
    end
    put_bit(~give_ack);
  endtask

  function automatic logic [6:0] my_dev();
    return exp_addr(strap_hi, strap_lo);
  endfunction

  task automatic read_run(input int n, input logic [7:0] first, input string req);
    logic a;
    logic [7:0] d;
    i2c_start();
    send_byte({my_dev(), 1'b1}, a);
    check(a, req, a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, k < n - 1);
      check(d == mem[8'(first + k)], req, d, mem[8'(first + k)]);
    end
    i2c_stop();
  endtask

  task automatic t_reset();
    check(sda_oe == 0, "R11 sda released", sda_oe, 0);
    check(reg_we == 0 && reg_re == 0, "R11 strobes idle", {reg_we, reg_re}, 0);
  endtask

  task automatic t_reset_read();
    read_run(2, 8'h00, "R7 start at 00h after reset");
    read_run(1, 8'h02, "R7 resume past last read");
  endtask

  task automatic t_addr_table();
    logic a;
    for (int h = 0; h < 4; h++) begin
      for (int l = 0; l < 4; l++) begin
        strap_hi = 2'(h);
        strap_lo = 2'(l);
        wclk(5);
        i2c_start();
        send_byte({exp_addr(2'(h), 2'(l)), 1'b0}, a);
        i2c_stop();
        check(a, "R2 strap address acked", a, 1);
        i2c_start();
        send_byte({exp_addr(2'(h), 2'(l)) ^ 7'h40, 1'b0}, a);
        i2c_stop();
        check(!a, "R3 foreign address not acked", a, 0);
      end
    end
    strap_hi = 2'd1;
    strap_lo = 2'd2;
    wclk(5);
  endtask

  task automatic t_write_burst();
    logic a;
    logic [7:0] dat [3] = '{8'hA5, 8'h3C, 8'hF0};
    int w0 = we_cnt;
    i2c_start();
    send_byte({my_dev(), 1'b0}, a);
    send_byte(8'h10, a);
    check(a, "R4 sub-address acked", a, 1);
    for (int k = 0; k < 3; k++) begin
      send_byte(dat[k], a);
      check(a, "R4 data byte acked", a, 1);
    end
    i2c_stop();
    check(we_cnt - w0 == 3, "R4 write strobe count", we_cnt - w0, 3);
    for (int k = 0; k < 3; k++)
      check(mem[8'(8'h10 + k)] == dat[k], "R4 consecutive offsets", mem[8'(8'h10 + k)], dat[k]);
    read_run(3, 8'h10, "R6 read from written sub-address");
  endtask

  task automatic t_sub_only();
    logic a;
    int w0 = we_cnt;
    i2c_start();
    send_byte({my_dev(), 1'b0}, a);
    send_byte(8'h20, a);
    i2c_stop();
    check(we_cnt == w0, "R5 pointer-only write stores nothing", we_cnt - w0, 0);
    read_run(2, 8'h20, "R6 read from pointer-only write");
    read_run(1, 8'h22, "R7 resume after pointer read");
  endtask

  task automatic t_nack();
    logic a, v;
    logic [7:0] d;
    int r0;
    i2c_start();
    send_byte({my_dev(), 1'b1}, a);
    recv_byte(d, 1'b0);
    r0 = re_cnt;
    for (int k = 0; k < 9; k++) begin
      get_bit(v);
      check(v == 1, "R8 SDA released after NACK", v, 1);
    end
    i2c_stop();
    check(re_cnt == r0, "R8 no read strobe after NACK", re_cnt - r0, 0);
  endtask

  task automatic t_rstart();
    logic a;
    logic [7:0] d;
    i2c_start();
    send_byte({my_dev(), 1'b0}, a);
    send_byte(8'h30, a);
    i2c_start();
    send_byte({my_dev(), 1'b1}, a);
    check(a, "R9 address after repeated start acked", a, 1);
    recv_byte(d, 1'b0);
    i2c_stop();
    check(d == mem[8'h30], "R9 read after repeated start", d, mem[8'h30]);
  endtask

  task automatic t_disabled();
    logic a;
    int w0 = we_cnt, o0 = oe_cnt;
    en = 1'b0;
    wclk(5);
    i2c_start();
    send_byte({my_dev(), 1'b0}, a);
    check(!a, "R1 no ack while disabled", a, 0);
    send_byte(8'h40, a);
    send_byte(8'h99, a);
    i2c_stop();
    check(we_cnt == w0, "R1 no write while disabled", we_cnt - w0, 0);
    check(oe_cnt == o0, "R1 SDA never pulled while disabled", oe_cnt - o0, 0);
    en = 1'b1;
    wclk(5);
  endtask

  task automatic t_bad_addr();
    logic a;
    int w0 = we_cnt;
    i2c_start();
    send_byte({my_dev() ^ 7'h01, 1'b0}, a);
    check(!a, "R3 mismatched address not acked", a, 0);
    send_byte(8'h50, a);
    check(!a, "R3 later byte not acked", a, 0);
    send_byte(8'h77, a);
    i2c_stop();
    check(we_cnt == w0, "R3 no write after mismatch", we_cnt - w0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    wclk(5);
    t_reset();
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_reset_read();
    t_addr_table();
    t_write_burst();
    t_sub_only();
    t_nack();
    t_rstart();
    t_disabled();
    t_bad_addr();
    check(bad_drive == 0, "R10 SDA drive moved with SCL high", bad_drive, 0);
    done = 1;
    summary();
  end

endmodule